// File: doc/BRIEF.md
# Clock Generator Serial Configuration Slave

This block is a receive-only slave on a two-wire serial bus. Its job is to take one block-write transaction and load the control fields of a clock generator. A fast system clock oversamples the bus lines. Each line passes through a two-stage synchronizer and a glitch filter, and the filtered lines are checked for start and stop conditions. The slave answers only one fixed device address. When that address matches, it acknowledges every byte and loads the control fields from the data bytes that follow.

A transaction runs in this order: start, device address, a command byte, a byte-count byte, then the data bytes, then stop. The command byte and the byte-count byte are acknowledged, but their values do not matter. The first data bytes load the frequency-select code, the frequency-source flag, the operating mode and the per-output clock enables. Later data bytes are acknowledged and dropped. The decoded fields drive the clock generator directly. The output frequency code comes either from the external select pins or from the register code, depending on the source flag.

Top module: `clkcfg_serial_slave`

## Requirements
- R1: Only an address byte of exactly 8'b11010010 is acknowledged. After any other address the slave drives no acknowledge and writes nothing until the next start condition.
- R2: Every byte is assembled with the first bit received as bit 7 and the last as bit 0.
- R3: The bytes after the address are the command byte, the byte-count byte, then data byte 0, 1, 2 and so on. Every byte of a matched transaction, including data bytes 3 to 7, is acknowledged. Only data bytes 0 to 2 change any output.
- R4: In data byte 0, bit 2 sets register code bit 3 and bits 6:4 set register code bits 2:0. Bit 3 is the source flag (useRegTable). When the flag is 1, freqCode equals the register code. When it is 0, freqCode equals fsPins.
- R5: Data byte 0 bits 1:0 set the mode. 2'b10 sets spreadEn. 2'b11 sets triStateAll. 2'b00 and 2'b01 both leave spreadEn and triStateAll at 0.
- R6: Data byte 1 bits 3:0 load clkEn[3:0] and data byte 2 bits 6:5 load clkEn[5:4]. A 0 disables that output.
- R7: Data byte 0 bit 7, data byte 1 bits 7:4 and data byte 2 bit 7 are reserved. Writing 1 to any of them has no effect on any output.
- R8: In a matched transaction, sdaPullLow goes high after the SCL falling edge that ends the eighth bit of each byte. It stays high through the ninth SCL high phase and drops after the following SCL falling edge.
- R9: A start or stop condition in the middle of a byte discards that partial byte. A stop returns the slave to idle, and a start begins a new address phase. Fields written earlier keep their values.
- R10: A pulse on SCL or SDA that lasts fewer than FILT_LEN system clocks is ignored.
- R11: After reset: freqCode follows fsPins, useRegTable, spreadEn and triStateAll are 0, every clkEn bit is 1, and sdaPullLow is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line as seen at the pin |
| sdaIn | input | 1 | Serial data line as seen at the pin (wired bus value) |
| sdaPullLow | output | 1 | When high, the open-drain driver pulls SDA low (acknowledge) |
| fsPins | input | 4 | External frequency-select pins |
| freqCode | output | 4 | Selected frequency code for the generator |
| useRegTable | output | 1 | 1 when the frequency code comes from the register |
| spreadEn | output | 1 | Spread-spectrum request |
| triStateAll | output | 1 | Request to three-state all clock outputs |
| clkEn | output | 6 | Per-output clock enables, 1 means running |

## Verification
The assertions assume that SCL and SDA come from a master that changes SDA only while SCL is low, except to make start and stop conditions. They also assume that any pulse meant to count stays level for well over FILT_LEN system clocks. The acknowledge check further assumes the master never makes a start or stop while the slave is holding SDA low. The stimulus holds each bus phase for eight system clocks and releases SDA during every ninth clock. The only short pulses it makes are deliberate two-cycle SCL spikes while SCL is low, which test the filter.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int NUM_EN     = 6;   // clock enables driven by the bank
  localparam int NREG       = 3;   // data bytes that carry decoded fields
  localparam int FIRST_DATA = 3;   // byte position of data byte 0 (addr, cmd, count precede)
  localparam int IDX_W      = 4;   // saturating byte position counter
  localparam int WIDX_W     = $clog2(NREG);

  typedef enum logic [2:0] {
    S_IDLE, S_RECV, S_ACKWAIT, S_ACK, S_IGNORE
  } rxState_t;

  typedef struct packed {
    logic              wrEn;
    logic [WIDX_W-1:0] wrIdx;
    logic [7:0]        wrData;
  } cfgStrobe_t;
endpackage

// File: rtl/clkcfg_glitch_filter.sv
module clkcfg_glitch_filter #(
  parameter int   FILT_LEN = 3,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);
  localparam int CNT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

  logic sync1, sync2;
  logic [CNT_W-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1    <= RST_VAL;
      sync2    <= RST_VAL;
      cleanOut <= RST_VAL;
      runCnt   <= '0;
    end else begin
      sync1 <= rawIn;
      sync2 <= sync1;
      if (sync2 == cleanOut) begin
        runCnt <= '0;
      end else if (runCnt == CNT_W'(FILT_LEN - 1)) begin
        cleanOut <= sync2;
        runCnt   <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end

  generate
    if (FILT_LEN >= 2) begin : g_chk
      // R10: the filtered level only moves after the synchronized level held for two samples
      a_r10_filter_settled: assert property (@(posedge clk) disable iff (!rstN)
        (cleanOut != $past(cleanOut)) |-> ($past(sync2) == $past(sync2, 2)));
    end
  endgenerate
endmodule

// File: rtl/clkcfg_ctrl.sv
module clkcfg_ctrl
  import clkcfg_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR = 8'b11010010,
  parameter int         FILT_LEN = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output cfgStrobe_t strb,
  output logic       sdaPullLow
);
  logic [1:0] rawLines, cleanLines;
  assign rawLines = {sclIn, sdaIn};

  generate
    for (genvar gi = 0; gi < 2; gi++) begin : g_filt
      clkcfg_glitch_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_filt (
        .clk(clk), .rstN(rstN), .rawIn(rawLines[gi]), .cleanOut(cleanLines[gi])
      );
    end
  endgenerate

  logic sclF, sdaF, sclQ, sdaQ;
  assign sclF = cleanLines[1];
  assign sdaF = cleanLines[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclF;
      sdaQ <= sdaF;
    end
  end

  logic sclRise, sclFall, startDet, stopDet;
  assign sclRise  =  sclF & ~sclQ;
  assign sclFall  = ~sclF &  sclQ;
  assign startDet =  sclF &  sclQ &  sdaQ & ~sdaF;
  assign stopDet  =  sclF &  sclQ & ~sdaQ &  sdaF;

  rxState_t         state;
  logic [2:0]       bitCnt;
  logic [6:0]       shReg;
  logic [IDX_W-1:0] byteIdx;
  logic [7:0]       rxByte;
  logic             lastBit;

  assign rxByte  = {shReg, sdaF};
  assign lastBit = (state == S_RECV) && sclRise && (bitCnt == 3'd7);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      bitCnt     <= '0;
      shReg      <= '0;
      byteIdx    <= '0;
      sdaPullLow <= 1'b0;
    end else if (startDet) begin
      state      <= S_RECV;
      bitCnt     <= '0;
      byteIdx    <= '0;
      sdaPullLow <= 1'b0;
    end else if (stopDet) begin
      state      <= S_IDLE;
      sdaPullLow <= 1'b0;
    end else begin
      case (state)
        S_RECV: if (sclRise) begin
          shReg  <= rxByte[6:0];
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == 3'd7) begin
            if (byteIdx == '0 && rxByte != DEV_ADDR) state <= S_IGNORE;
            else                                     state <= S_ACKWAIT;
          end
        end
        S_ACKWAIT: if (sclFall) begin
          sdaPullLow <= 1'b1;
          state      <= S_ACK;
        end
        S_ACK: if (sclFall) begin
          sdaPullLow <= 1'b0;
          state      <= S_RECV;
          bitCnt     <= '0;
          if (byteIdx != '1) byteIdx <= byteIdx + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strb.wrEn   = lastBit && (byteIdx >= IDX_W'(FIRST_DATA))
                          && (byteIdx <  IDX_W'(FIRST_DATA + NREG));
    strb.wrIdx  = WIDX_W'(byteIdx - IDX_W'(FIRST_DATA));
    strb.wrData = rxByte;
  end

  // R1: a rejected address never leads to an acknowledge or a write
  a_r1_ignore_silent: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IGNORE) |-> (!sdaPullLow && !strb.wrEn));
  // R9: a stop condition always parks the sequencer
  a_r9_stop_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (state == S_IDLE));
  // R8: the acknowledge drive does not move while SCL is high
  a_r8_ack_steady: assert property (@(posedge clk) disable iff (!rstN)
    (sclF && sclQ && !startDet && !stopDet) |=> $stable(sdaPullLow));
endmodule

// File: rtl/clkcfg_datapath.sv
module clkcfg_datapath
  import clkcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strb,
  input  logic [3:0]        fsPins,
  output logic [3:0]        freqCode,
  output logic              useRegTable,
  output logic              spreadEn,
  output logic              triStateAll,
  output logic [NUM_EN-1:0] clkEn
);
  logic [3:0]        selReg;
  logic              srcReg;
  logic [1:0]        modeReg;
  logic [NUM_EN-1:0] enReg;
  logic              unusedRsvd;

  assign unusedRsvd = strb.wrData[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg  <= '0;
      srcReg  <= 1'b0;
      modeReg <= 2'b00;
      enReg   <= '1;
    end else if (strb.wrEn) begin
      case (strb.wrIdx)
        WIDX_W'(0): begin
          selReg  <= {strb.wrData[2], strb.wrData[6:4]};
          srcReg  <= strb.wrData[3];
          modeReg <= strb.wrData[1:0];
        end
        WIDX_W'(1): enReg[3:0] <= strb.wrData[3:0];
        WIDX_W'(2): enReg[5:4] <= strb.wrData[6:5];
        default: ;
      endcase
    end
  end

  always_comb begin
    freqCode    = srcReg ? selReg : fsPins;
    useRegTable = srcReg;
    spreadEn    = (modeReg == 2'b10);
    triStateAll = (modeReg == 2'b11);
    clkEn       = enReg;
  end

  // R3: writes only ever target one of the decoded bytes
  a_r3_idx_in_range: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |-> (int'(strb.wrIdx) < NREG));
  // R6: enables move only in the cycle after a write strobe
  a_r6_en_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.wrEn) |-> $stable(clkEn));
  // R5: the two mode requests are exclusive
  a_r5_mode_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(spreadEn && triStateAll));
endmodule

// File: rtl/clkcfg_serial_slave.sv
module clkcfg_serial_slave
  import clkcfg_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR = 8'b11010010,
  parameter int         FILT_LEN = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaPullLow,
  input  logic [3:0] fsPins,
  output logic [3:0] freqCode,
  output logic       useRegTable,
  output logic       spreadEn,
  output logic       triStateAll,
  output logic [5:0] clkEn
);
  cfgStrobe_t strb;

  clkcfg_ctrl #(.DEV_ADDR(DEV_ADDR), .FILT_LEN(FILT_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .strb(strb), .sdaPullLow(sdaPullLow)
  );

  clkcfg_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .fsPins(fsPins),
    .freqCode(freqCode), .useRegTable(useRegTable), .spreadEn(spreadEn),
    .triStateAll(triStateAll), .clkEn(clkEn)
  );
endmodule

// File: tb/clkcfg_serial_slave_bench.sv
module clkcfg_serial_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam logic [7:0] ADDR = 8'b11010010;

  logic clk = 1'b0, rstN = 1'b0, sclM = 1'b1, sdaM = 1'b1;
  logic [3:0] fsPins = 4'h0;
  logic sdaPullLow, useRegTable, spreadEn, triStateAll, sdaBus;
  logic [3:0] freqCode;
  logic [5:0] clkEn;

  assign sdaBus = sdaM & ~sdaPullLow;

  clkcfg_serial_slave u_clkcfg_serial_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaPullLow(sdaPullLow),
    .fsPins(fsPins), .freqCode(freqCode), .useRegTable(useRegTable),
    .spreadEn(spreadEn), .triStateAll(triStateAll), .clkEn(clkEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0, nFails = 0;
  bit done = 0, glitchOn = 0;
  logic [3:0] expSel = 4'h0;
  logic       expSrc = 1'b0;
  logic [1:0] expMode = 2'b00;
  logic [5:0] expEn = 6'h3F;
  logic [7:0] dat [8];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitQ(); repeat (Q) @(negedge clk); endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b0; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b1; waitQ();
  endtask

  task automatic sendBit(input logic b);
    if (glitchOn) begin
      sclM = 1'b1; repeat (2) @(negedge clk); sclM = 1'b0; repeat (2) @(negedge clk);
    end
    sdaM = b; waitQ(); sclM = 1'b1; waitQ(); waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ();
    ack = sdaPullLow;
    waitQ(); sclM = 1'b0; waitQ();
  endtask

  // bench model of the decoded fields (R4..R7)
  task automatic modelWrite(input int idx, input logic [7:0] d);
    case (idx)
      0: begin expSel = {d[2], d[6:4]}; expSrc = d[3]; expMode = d[1:0]; end
      1: expEn[3:0] = d[3:0];
      2: expEn[5:4] = d[6:5];
      default: ;
    endcase
  endtask

  task automatic checkOuts(input string tag);
    chk({tag, " R4 freqCode"}, freqCode, expSrc ? expSel : fsPins);
    chk({tag, " R4 useRegTable"}, useRegTable, expSrc);
    chk({tag, " R5 spreadEn"}, spreadEn, expMode == 2'b10);
    chk({tag, " R5 triStateAll"}, triStateAll, expMode == 2'b11);
    chk({tag, " R6 clkEn"}, clkEn, expEn);
    chk({tag, " R8 released"}, sdaPullLow, 1'b0);
  endtask

  task automatic runTxn(input logic [7:0] addr, input int n, input string tag);
    logic ack;
    logic hit;
    hit = (addr == ADDR);
    busStart();
    sendByte(addr, ack);
    chk({tag, " R1 addr ack"}, ack, hit);
    sendByte(8'($urandom), ack);
    chk({tag, " R8 cmd ack"}, ack, hit);
    sendByte(8'(n), ack);
    chk({tag, " R8 count ack"}, ack, hit);
    for (int i = 0; i < n; i++) begin
      sendByte(dat[i], ack);
      chk({tag, " R3 data ack"}, ack, hit);
      if (hit) modelWrite(i, dat[i]);
    end
    busStop();
    waitQ();
    checkOuts(tag);
  endtask

  task automatic partialBits(input logic [7:0] v, input int cnt);
    for (int i = 0; i < cnt; i++) sendBit(v[7-i]);
  endtask

  initial begin
    logic ack;
    void'($urandom(32'h00C1_0C4E));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    fsPins = 4'h9; #1;
    checkOuts("R11 reset");

    // R2 R4 R5: sel = 1101, source register, spread spectrum
    dat[0] = 8'h5E;
    runTxn(ADDR, 1, "R2 directed byte0");
    chk("R2 freqCode order", freqCode, 4'hD);

    // R6: disable some outputs
    dat[0] = 8'h5E; dat[1] = 8'h05; dat[2] = 8'h40;
    runTxn(ADDR, 3, "R6 enables");

    // R7: reserved bits written as ones
    dat[0] = 8'hFF; dat[1] = 8'hF0; dat[2] = 8'h80;
    runTxn(ADDR, 3, "R7 reserved");
    chk("R7 clkEn after reserved", clkEn, 6'h00);
    chk("R7 freqCode", freqCode, 4'hF);

    // R5: mode 01 behaves as normal
    dat[0] = 8'h01; dat[1] = 8'h0F; dat[2] = 8'h60;
    runTxn(ADDR, 3, "R5 mode01");
    fsPins = 4'h3; #1;
    chk("R4 pins follow", freqCode, 4'h3);

    // R1: wrong address changes nothing
    dat[0] = 8'h7B; dat[1] = 8'h00; dat[2] = 8'h00;
    runTxn(8'hD3, 3, "R1 mismatch");

    // R3: eight data bytes, last five ignored
    dat[0] = 8'h2A; dat[1] = 8'h0A; dat[2] = 8'h20;
    for (int i = 3; i < 8; i++) dat[i] = 8'hFF;
    runTxn(ADDR, 8, "R3 long");

    // R9: stop in the middle of data byte 0
    busStart(); sendByte(ADDR, ack); sendByte(8'h00, ack); sendByte(8'h01, ack);
    partialBits(8'h7F, 5);
    busStop(); waitQ();
    checkOuts("R9 stop midbyte");

    // R9: start in the middle of data byte 0, then a full transaction
    busStart(); sendByte(ADDR, ack); sendByte(8'h00, ack); sendByte(8'h01, ack);
    partialBits(8'h7F, 4);
    dat[0] = 8'h22;
    runTxn(ADDR, 1, "R9 start midbyte");

    // R10: short SCL spikes while SCL is low
    glitchOn = 1;
    dat[0] = 8'h4A; dat[1] = 8'h09; dat[2] = 8'h40;
    runTxn(ADDR, 3, "R10 glitch");
    glitchOn = 0;

    // random mix
    for (int t = 0; t < 18; t++) begin
      logic [7:0] a;
      int n;
      a = ($urandom_range(0, 3) == 0) ? 8'($urandom) : ADDR;
      n = $urandom_range(0, 8);
      for (int i = 0; i < 8; i++) dat[i] = 8'($urandom);
      fsPins = 4'($urandom);
      runTxn(a, n, "R3 random");
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog R3 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule